// File: doc/BRIEF.md
# Guarded Operand Stack

This block is the data stack of a stack machine. The two operands of a calculation and its result live on this stack as positions, not in separate registers. A sequencer issues one command per clock: push a value, drop the top entry, overwrite the top entry with the result of a one-input operation, replace the two top entries with the result of a two-input operation, or check that two operands are present. The result value travels in on the same data input as pushed values. The arithmetic is computed outside the block.

Every command is checked against the current fill level before anything is written. A command that would read a position that does not hold an entry raises an underflow fault. A command that would add an entry to a full stack raises an overflow fault. Either way the stack keeps its contents and its depth. The two top entries and the depth are available on registered outputs, so the operand fetch costs no extra cycle. Entries below the top two sit in a memory with a synchronous read port, which block RAM can implement.

Top module: `opstk_top`

## Requirements
- R1: A synchronous reset sets depth to 0 and both fault flags to 0.
- R2: PUSH (op code 1) at depth below DEPTH raises depth by one, sets top0 to the data input and moves the previous top0 to top1.
- R3: PUSH at depth equal to DEPTH sets ovf_fault and leaves the depth and the top entries unchanged.
- R4: DROP (op code 2) at depth at least 1 lowers depth by one, moves top1 to top0 and brings the third entry up to top1.
- R5: BINARY (op code 4) at depth at least 2 lowers depth by one, writes the data input to top0 and brings the third entry up to top1.
- R6: UNARY (op code 3) at depth at least 1 writes the data input to top0 and leaves depth and top1 unchanged.
- R7: DROP or UNARY at depth 0, and BINARY or PEEK at depth below 2, set unf_fault and leave the depth and the top entries unchanged.
- R8: Fault flags are valid in the cycle after the command and last one cycle only. At most one flag is set. The read check is made before the write check, so underflow wins when both fail.
- R9: PEEK (op code 5) at depth at least 2 raises no fault and changes nothing.
- R10: IDLE (op code 0) and the unused codes 6 and 7 change nothing and raise no fault.
- R11: Each result shows on the outputs one clock after the command is sampled. Entries deeper than the top two come back intact after any run of pushes and drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Command code: 0 idle, 1 push, 2 drop, 3 unary, 4 binary, 5 peek |
| din | input | WIDTH | Value to push, or the result for unary and binary |
| top0 | output | WIDTH | Top entry, valid when depth is at least 1 |
| top1 | output | WIDTH | Entry below the top, valid when depth is at least 2 |
| depth | output | $clog2(DEPTH)+1 | Number of entries held |
| ovf_fault | output | 1 | One-cycle pulse: push refused because the stack is full |
| unf_fault | output | 1 | One-cycle pulse: command refused because too few entries are held |

## Verification
The bench targets the fill levels where the guards switch. It uses depth 0 and 1 for two-operand commands, depth 0 for drops, and a full stack for pushes, including back-to-back refused pushes. A design with an off-by-one guard either corrupts the depth or lets it wrap, or it faults on a legal command. A design that lets a flag stick fails on the next accepted command. Long random runs push entries deep into memory and drop them again. A wrong spill address or a missing read-during-write bypass then brings the wrong value up to top1 after a drop or a binary operation.

// File: rtl/opstk_pkg.sv
package opstk_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PUSH   = 3'd1,
    OP_DROP   = 3'd2,
    OP_UNARY  = 3'd3,
    OP_BINARY = 3'd4,
    OP_PEEK   = 3'd5
  } op_e;

  // What a command needs from the stack and what it does to the depth.
  typedef struct packed {
    logic       known;
    logic [1:0] need;
    logic       grow;
    logic       shrink;
  } op_info_t;

  function automatic op_info_t op_decode(input logic [2:0] code);
    op_info_t r;
    r = '{known: 1'b1, need: 2'd0, grow: 1'b0, shrink: 1'b0};
    case (code)
      OP_IDLE:   r.need = 2'd0;
      OP_PUSH:   r.grow = 1'b1;
      OP_DROP:   begin r.need = 2'd1; r.shrink = 1'b1; end
      OP_UNARY:  r.need = 2'd1;
      OP_BINARY: begin r.need = 2'd2; r.shrink = 1'b1; end
      OP_PEEK:   r.need = 2'd2;
      default:   r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/opstk_guard.sv
module opstk_guard
  import opstk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = $clog2(DEPTH) + 1
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] depth,
  output logic          accept,
  output logic          grow,
  output logic          shrink,
  output logic          ovf,
  output logic          unf
);
  localparam logic [DW-1:0] FULL = DW'(DEPTH);

  op_info_t info;
  logic     read_bad;
  logic     write_bad;

  always_comb begin
    info      = op_decode(op);
    // read availability first: it decides underflow and masks overflow
    read_bad  = info.known && (depth < DW'(info.need));
    write_bad = info.known && info.grow && (depth == FULL);
    unf       = read_bad;
    ovf       = write_bad && !read_bad;
    accept    = info.known && !read_bad && !write_bad;
    grow      = accept && info.grow;
    shrink    = accept && info.shrink;
  end

endmodule

// File: rtl/opstk_ram.sv
module opstk_ram #(
  parameter int WIDTH = 32,
  parameter int WORDS = 16,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // write-first read port: a word written this cycle is returned at once
  always_ff @(posedge clk) begin
    if (we && (waddr == raddr)) rdata <= wdata;
    else                        rdata <= mem[raddr];
  end

endmodule

// File: rtl/opstk_tos.sv
module opstk_tos
  import opstk_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] din,
  input  logic             accept,
  input  logic             ovf_in,
  input  logic             unf_in,
  input  logic [DW-1:0]    depth_nxt,
  input  logic [WIDTH-1:0] third,
  output logic [WIDTH-1:0] top0,
  output logic [WIDTH-1:0] top1,
  output logic [DW-1:0]    depth,
  output logic             ovf_fault,
  output logic             unf_fault
);

  always_ff @(posedge clk) begin
    if (rst) begin
      top0      <= '0;
      top1      <= '0;
      depth     <= '0;
      ovf_fault <= 1'b0;
      unf_fault <= 1'b0;
    end else begin
      ovf_fault <= ovf_in;
      unf_fault <= unf_in;
      depth     <= depth_nxt;
      if (accept) begin
        case (op)
          OP_PUSH:   begin top0 <= din;  top1 <= top0;  end
          OP_DROP:   begin top0 <= top1; top1 <= third; end
          OP_UNARY:  top0 <= din;
          OP_BINARY: begin top0 <= din;  top1 <= third; end
          default:   ;
        endcase
      end
    end
  end

endmodule

// File: rtl/opstk_top.sv
module opstk_top
  import opstk_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] top0,
  output logic [WIDTH-1:0] top1,
  output logic [DW-1:0]    depth,
  output logic             ovf_fault,
  output logic             unf_fault
);
  localparam int RAM_WORDS = (DEPTH > 2) ? DEPTH - 2 : 1;
  localparam int RAW       = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1;

  logic             accept, grow, shrink, g_ovf, g_unf;
  logic [DW-1:0]    depth_nxt;
  logic             spill_we;
  logic [RAW-1:0]   spill_addr, fill_addr;
  logic [WIDTH-1:0] third;

  opstk_guard #(.DEPTH(DEPTH), .DW(DW)) u_guard (
    .op     (op),
    .depth  (depth),
    .accept (accept),
    .grow   (grow),
    .shrink (shrink),
    .ovf    (g_ovf),
    .unf    (g_unf)
  );

  always_comb begin
    depth_nxt = depth;
    if (grow)        depth_nxt = depth + DW'(1);
    else if (shrink) depth_nxt = depth - DW'(1);
    // a push at depth d >= 2 spills the old second entry to word d-2
    spill_we   = grow && (depth >= DW'(2));
    spill_addr = RAW'(depth - DW'(2));
    // keep the word below top1 of the next state on the read port
    fill_addr  = (depth_nxt >= DW'(3)) ? RAW'(depth_nxt - DW'(3)) : '0;
  end

  opstk_ram #(.WIDTH(WIDTH), .WORDS(RAM_WORDS), .AW(RAW)) u_ram (
    .clk   (clk),
    .we    (spill_we),
    .waddr (spill_addr),
    .wdata (top1),
    .raddr (fill_addr),
    .rdata (third)
  );

  opstk_tos #(.WIDTH(WIDTH), .DW(DW)) u_tos (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .din       (din),
    .accept    (accept),
    .ovf_in    (g_ovf),
    .unf_in    (g_unf),
    .depth_nxt (depth_nxt),
    .third     (third),
    .top0      (top0),
    .top1      (top1),
    .depth     (depth),
    .ovf_fault (ovf_fault),
    .unf_fault (unf_fault)
  );

endmodule

// File: rtl/opstk_chk.sv
module opstk_chk #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int DW    = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] top0,
  input logic [WIDTH-1:0] top1,
  input logic [DW-1:0]    depth,
  input logic             ovf_fault,
  input logic             unf_fault
);
  localparam logic [DW-1:0] FULL = DW'(DEPTH);

  p_bound_r2: assert property (@(posedge clk) disable iff (rst)
    depth <= FULL);

  p_push_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1 && depth < FULL) |=>
      (depth == $past(depth) + DW'(1) && top0 == $past(din) && top1 == $past(top0)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1 && depth == FULL) |=>
      (ovf_fault && depth == $past(depth) && top0 == $past(top0)));

  p_drop_ok_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 && depth >= DW'(1)) |=>
      (depth == $past(depth) - DW'(1) && top0 == $past(top1)));

  p_binary_ok_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd4 && depth >= DW'(2)) |=>
      (depth == $past(depth) - DW'(1) && top0 == $past(din) && !unf_fault));

  p_unary_ok_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd3 && depth >= DW'(1)) |=>
      (depth == $past(depth) && top0 == $past(din) && top1 == $past(top1)));

  p_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (((op == 3'd2 || op == 3'd3) && depth == '0) ||
     ((op == 3'd4 || op == 3'd5) && depth < DW'(2))) |=>
      (unf_fault && depth == $past(depth)));

  p_one_flag_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_fault, unf_fault}));

  p_fault_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_fault || unf_fault) |-> (depth == $past(depth)));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0 || op == 3'd6 || op == 3'd7) |=>
      (!ovf_fault && !unf_fault && $stable(depth) && $stable(top0) && $stable(top1)));

endmodule

bind opstk_top opstk_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op        (op),
  .din       (din),
  .top0      (top0),
  .top1      (top1),
  .depth     (depth),
  .ovf_fault (ovf_fault),
  .unf_fault (unf_fault)
);

// File: tb/opstk_top_bench.sv
module opstk_top_bench;
  localparam int WIDTH = 32;
  localparam int DEPTH = 16;
  localparam int DW    = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       op  = 3'd0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] top0, top1;
  logic [DW-1:0]    depth;
  logic             ovf_fault, unf_fault;

  always #4 clk = ~clk;

  opstk_top #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_opstk_top (
    .clk(clk), .rst(rst), .op(op), .din(din),
    .top0(top0), .top1(top1), .depth(depth),
    .ovf_fault(ovf_fault), .unf_fault(unf_fault)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [WIDTH-1:0] model [DEPTH];
  int md = 0;

  task automatic cmp(input string tag, input string what,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int need_of(input logic [2:0] c);
    case (c)
      3'd2, 3'd3: return 1;
      3'd4, 3'd5: return 2;
      default:    return 0;
    endcase
  endfunction

  // apply one command, let one edge pass, compare against the model
  task automatic step(input logic [2:0] c, input logic [WIDTH-1:0] d);
    bit    e_unf, e_ovf;
    string tag;
    op  = c;
    din = d;
    @(posedge clk);
    #2;
    e_unf = (c <= 3'd5) && (need_of(c) > md);
    e_ovf = !e_unf && (c == 3'd1) && (md == DEPTH);
    if (e_unf)            tag = "R7";
    else if (e_ovf)       tag = "R3";
    else case (c)
      3'd1:    tag = "R2";
      3'd2:    tag = "R4";
      3'd3:    tag = "R6";
      3'd4:    tag = "R5";
      3'd5:    tag = "R9";
      default: tag = "R10";
    endcase
    if (!e_unf && !e_ovf) begin
      case (c)
        3'd1: begin model[md] = d; md++; end
        3'd2: md--;
        3'd3: model[md-1] = d;
        3'd4: begin md--; model[md-1] = d; end
        default: ;
      endcase
    end
    cmp(tag, "depth (R11)", WIDTH'(depth), WIDTH'(md));
    cmp(tag, "ovf_fault (R8)", WIDTH'(ovf_fault), WIDTH'(e_ovf));
    cmp(tag, "unf_fault (R8)", WIDTH'(unf_fault), WIDTH'(e_unf));
    if (md >= 1) cmp(tag, "top0", top0, model[md-1]);
    if (md >= 2) cmp(tag, "top1 (R11)", top1, model[md-2]);
    op = 3'd0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    op  = 3'd0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    md = 0;
    cmp("R1", "depth after reset", WIDTH'(depth), '0);
    cmp("R1", "ovf after reset", WIDTH'(ovf_fault), '0);
    cmp("R1", "unf after reset", WIDTH'(unf_fault), '0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [WIDTH-1:0] rv;
    rv = $urandom(32'd20240611);
    do_reset();
    // directed corners at the empty end
    step(3'd2, 32'h0);           // R7 drop at 0
    step(3'd3, 32'h11);          // R7 unary at 0
    step(3'd5, 32'h0);           // R7 peek at 0
    step(3'd1, 32'hA0A0_0001);   // R2
    step(3'd4, 32'h22);          // R7 binary at 1
    step(3'd5, 32'h0);           // R7 peek at 1
    step(3'd1, 32'hA0A0_0002);
    step(3'd5, 32'h0);           // R9 peek at 2
    step(3'd3, 32'hB0B0_0003);   // R6
    step(3'd4, 32'hC0C0_0004);   // R5
    // fill, refused pushes back to back, idle codes, drain
    for (int i = 0; i < DEPTH; i++) step(3'd1, $urandom());
    step(3'd1, 32'hDEAD_0001);   // R3
    step(3'd1, 32'hDEAD_0002);   // R3 again, flag must pulse again
    step(3'd0, 32'h0);           // R10, R8 flag cleared
    step(3'd6, 32'h1);           // R10
    step(3'd7, 32'h2);           // R10
    step(3'd4, $urandom());      // R5 at full
    for (int i = 0; i < DEPTH; i++) step(3'd2, 32'h0);
    step(3'd2, 32'h0);           // R7 drop at 0
    // constrained random: drift up then down
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] c;
      r = int'($urandom_range(0, 99));
      if ((i / 500) % 2 == 0) c = (r < 45) ? 3'd1 : (r < 60) ? 3'd4 : (r < 72) ? 3'd2 :
                                  (r < 84) ? 3'd3 : (r < 92) ? 3'd5 : 3'($urandom_range(0, 7));
      else                      c = (r < 20) ? 3'd1 : (r < 50) ? 3'd2 : (r < 72) ? 3'd4 :
                                  (r < 84) ? 3'd3 : (r < 92) ? 3'd5 : 3'($urandom_range(0, 7));
      step(c, $urandom());
    end
    // reset with a loaded stack
    for (int i = 0; i < 5; i++) step(3'd1, $urandom());
    do_reset();
    step(3'd2, 32'h0);           // R7 after reset
    summary();
  end

endmodule